// File: doc/BRIEF.md
# Processor Power State Controller

This block tracks the power-management state of a processor core as a synchronous state machine clocked by an always-running reference clock. It moves between five states: running, halted after a HALT instruction, stop-granted, clock-stopped and snooping while stop-granted. The bus unit, the clock gating, the PLL and the cache are outside the block. The block only decides the state, raises one-cycle strobes that ask the bus unit for a HALT or stop-grant special cycle, and reports which groups of core inputs may be acted on.

A stop request is held off until the core reports that it is quiescent. Once granted, the request must be withdrawn for a minimum run of cycles before a new one is accepted. The external clock being stopped is modelled by a clock-present input. After the clock returns, the block waits a parameterized PLL start-up latency of uninterrupted clock presence before it goes back to stop-granted. Which state stop-grant was entered from decides whether a stop-grant strobe is raised.

Top module: `pwr_state_ctl`

## Requirements
- R1: On reset, `state_o` is 0 (running), both strobes are low and `recog_o` is 2'b11. State codes are 0 running, 1 halted, 2 stop-granted, 3 clock-stopped, 4 snooping. `recog_o` bit 0 enables the arbitration, snoop and flush group, and bit 1 enables all other inputs.
- R2: In running state with `recog_o[1]` high and no stop being granted, `halt_exec_i` moves the block to halted on the next edge, with `halt_cyc_o` high for that first halted cycle only.
- R3: In halted state, any one of `intr_i`, `nmi_i`, `smi_i`, `soft_rst_i` or `hard_rst_i` returns the block to running on the next edge.
- R4: From running or halted, a stop request is honoured only when `idle_i` is high. Until then the block stays in place. On entry to stop-granted from either of these states, `grant_cyc_o` is high for exactly the first cycle.
- R5: In stop-granted, `recog_o` is 2'b01, and `halt_exec_i`, `intr_i`, `nmi_i`, `smi_i` and `soft_rst_i` have no effect on the state.
- R6: In stop-granted with `stop_req_i` high and `clk_present_i` low, the next state is clock-stopped. There `recog_o` is 2'b00, and snoop, interrupt and stop-request changes have no effect.
- R7: Clock-stopped returns to stop-granted on the edge that samples `clk_present_i` high for the PLL_LAT-th consecutive time. A low sample restarts the count, and no `grant_cyc_o` is raised on this return.
- R8: In stop-granted, `snoop_i` high moves the block to snooping, where the stop request is ignored. When `snoop_i` falls it goes back to stop-granted without a strobe.
- R9: `stop_req_i` sampled low in stop-granted returns the block to running. For that first running cycle `recog_o` is 2'b01 and `halt_exec_i` is ignored. From the next cycle `recog_o` is 2'b11.
- R10: After leaving stop-granted, a new stop request is honoured only once `stop_req_i` has been sampled low on MIN_DEASSERT consecutive edges, counting the exit edge. A high sample before then restarts the count.
- R11: `hard_rst_i` forces running state from every state on the next edge and clears the latency and deassertion counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_i | input | 1 | Stop-clock request |
| halt_exec_i | input | 1 | HALT instruction executed |
| intr_i | input | 1 | Maskable interrupt break event |
| nmi_i | input | 1 | Non-maskable interrupt break event |
| smi_i | input | 1 | System-management interrupt break event |
| hard_rst_i | input | 1 | Core reset event, forces running state |
| soft_rst_i | input | 1 | Soft reset break event |
| idle_i | input | 1 | Core quiescent: writes drained, interrupts serviced |
| snoop_i | input | 1 | Snoop in progress |
| clk_present_i | input | 1 | External core clock is running |
| state_o | output | 3 | Current power state code |
| grant_cyc_o | output | 1 | One-cycle stop-grant special-cycle request |
| halt_cyc_o | output | 1 | One-cycle HALT special-cycle request |
| recog_o | output | 2 | Input-recognition enables per group |

## Verification
The bench builds the block with PLL_LAT of 4 and MIN_DEASSERT of 3. These small values let it sweep every clock-dropout position inside the latency window, and every deassertion gap from one cycle to one past the minimum. The expected transition edge is computed from the two parameters. It also walks each of the five break events out of halted state, and applies the core reset from each state.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [2:0] {
    PS_RUN     = 3'd0,
    PS_HALT    = 3'd1,
    PS_GRANT   = 3'd2,
    PS_CLKSTOP = 3'd3,
    PS_SNOOP   = 3'd4
  } pwr_state_e;

  localparam int unsigned RECOG_W = 2;

endpackage

// File: rtl/pwr_deassert_guard.sv
module pwr_deassert_guard #(
  parameter int unsigned MIN_DEASSERT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_clr_i,
  input  logic exit_evt_i,
  input  logic stop_req_i,
  output logic armed_o
);

  localparam int unsigned CNT_W = $clog2(MIN_DEASSERT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_DEASSERT - 1);
  localparam bit ONE_SHOT = (MIN_DEASSERT <= 1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (sync_clr_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (exit_evt_i) begin
      armed_d = ONE_SHOT;
      cnt_d   = CNT_W'(1);
    end else if (!armed_q) begin
      if (stop_req_i) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        armed_d = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_en = sync_clr_i | exit_evt_i | ~armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed_o = armed_q;

endmodule

// File: rtl/pwr_pll_timer.sv
module pwr_pll_timer #(
  parameter int unsigned PLL_LAT = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clk_present_i,
  output logic done_o
);

  localparam int unsigned CNT_W = $clog2(PLL_LAT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PLL_LAT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (!run_i || !clk_present_i) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = run_i & clk_present_i & at_last;

endmodule

// File: rtl/pwr_recog_mask.sv
module pwr_recog_mask
  import pwr_state_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_clr_i,
  input  logic               exit_evt_i,
  input  pwr_state_e         state_i,
  output logic [RECOG_W-1:0] recog_o
);

  logic wake_q, wake_d;

  assign wake_d = exit_evt_i & ~sync_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q <= 1'b0;
    end else begin
      wake_q <= wake_d;
    end
  end

  always_comb begin
    unique case (state_i)
      PS_RUN, PS_HALT:   recog_o = {~wake_q, 1'b1};
      PS_GRANT, PS_SNOOP: recog_o = 2'b01;
      default:           recog_o = 2'b00;
    endcase
  end

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_state_pkg::*;
#(
  parameter int unsigned PLL_LAT      = 2048,
  parameter int unsigned MIN_DEASSERT = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_req_i,
  input  logic       halt_exec_i,
  input  logic       intr_i,
  input  logic       nmi_i,
  input  logic       smi_i,
  input  logic       hard_rst_i,
  input  logic       soft_rst_i,
  input  logic       idle_i,
  input  logic       snoop_i,
  input  logic       clk_present_i,
  output logic [2:0] state_o,
  output logic       grant_cyc_o,
  output logic       halt_cyc_o,
  output logic [1:0] recog_o
);

  pwr_state_e         state_q, state_d;
  logic               grant_q, grant_d;
  logic               halt_q, halt_d;
  logic               exit_evt;
  logic               armed;
  logic               pll_done;
  logic               grant_ok;
  logic               any_brk;
  logic [RECOG_W-1:0] recog;

  pwr_deassert_guard #(
    .MIN_DEASSERT (MIN_DEASSERT)
  ) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_clr_i (hard_rst_i),
    .exit_evt_i (exit_evt),
    .stop_req_i (stop_req_i),
    .armed_o    (armed)
  );

  pwr_pll_timer #(
    .PLL_LAT (PLL_LAT)
  ) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         ((state_q == PS_CLKSTOP) && !hard_rst_i),
    .clk_present_i (clk_present_i),
    .done_o        (pll_done)
  );

  pwr_recog_mask u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_clr_i (hard_rst_i),
    .exit_evt_i (exit_evt),
    .state_i    (state_q),
    .recog_o    (recog)
  );

  assign grant_ok = stop_req_i & armed & idle_i;
  assign any_brk  = intr_i | nmi_i | smi_i | soft_rst_i;

  always_comb begin
    state_d  = state_q;
    grant_d  = 1'b0;
    halt_d   = 1'b0;
    exit_evt = 1'b0;
    if (hard_rst_i) begin
      state_d = PS_RUN;
    end else begin
      unique case (state_q)
        PS_RUN: begin
          if (grant_ok) begin
            state_d = PS_GRANT;
            grant_d = 1'b1;
          end else if (halt_exec_i && recog[1]) begin
            state_d = PS_HALT;
            halt_d  = 1'b1;
          end
        end
        PS_HALT: begin
          if (any_brk) begin
            state_d = PS_RUN;
          end else if (grant_ok) begin
            state_d = PS_GRANT;
            grant_d = 1'b1;
          end
        end
        PS_GRANT: begin
          if (!stop_req_i) begin
            state_d  = PS_RUN;
            exit_evt = 1'b1;
          end else if (!clk_present_i) begin
            state_d = PS_CLKSTOP;
          end else if (snoop_i) begin
            state_d = PS_SNOOP;
          end
        end
        PS_CLKSTOP: begin
          if (pll_done) state_d = PS_GRANT;
        end
        PS_SNOOP: begin
          if (!snoop_i) state_d = PS_GRANT;
        end
        default: state_d = PS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_RUN;
      grant_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      grant_q <= grant_d;
      halt_q  <= halt_d;
    end
  end

  assign state_o     = state_q;
  assign grant_cyc_o = grant_q;
  assign halt_cyc_o  = halt_q;
  assign recog_o     = recog;

endmodule

// File: rtl/pwr_state_ctl_chk.sv
module pwr_state_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_req_i,
  input logic       hard_rst_i,
  input logic       clk_present_i,
  input logic [2:0] state_o,
  input logic       grant_cyc_o,
  input logic       halt_cyc_o,
  input logic [1:0] recog_o
);

  a_r2_halt_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_cyc_o |-> (state_o == 3'd1) && ($past(state_o) == 3'd0));

  a_r4_grant_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_cyc_o |-> (state_o == 3'd2) && ($past(state_o) <= 3'd1));

  a_r5_grant_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2) |-> (recog_o == 2'b01));

  a_r6_stopped_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) |-> (recog_o == 2'b00));

  a_r6_enter_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && stop_req_i && !clk_present_i && !hard_rst_i) |=> (state_o == 3'd3));

  a_r7_silent_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) |=> !grant_cyc_o);

  a_r11_core_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_i |=> (state_o == 3'd0));

  a_r1_legal_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o <= 3'd4) && !(grant_cyc_o && halt_cyc_o));

endmodule

bind pwr_state_ctl pwr_state_ctl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stop_req_i    (stop_req_i),
  .hard_rst_i    (hard_rst_i),
  .clk_present_i (clk_present_i),
  .state_o       (state_o),
  .grant_cyc_o   (grant_cyc_o),
  .halt_cyc_o    (halt_cyc_o),
  .recog_o       (recog_o)
);

// File: tb/tb_pwr_state_ctl.sv
`timescale 1ns/1ps
module tb_pwr_state_ctl;

  localparam int LAT = 4;
  localparam int MIN = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop_req, halt_exec, intr, nmi, smi, hard_rst, soft_rst;
  logic       idle, snoop, clk_present;
  logic [2:0] state;
  logic       grant_cyc, halt_cyc;
  logic [1:0] recog;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pwr_state_ctl #(.PLL_LAT(LAT), .MIN_DEASSERT(MIN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req), .halt_exec_i(halt_exec),
    .intr_i(intr), .nmi_i(nmi), .smi_i(smi), .hard_rst_i(hard_rst),
    .soft_rst_i(soft_rst), .idle_i(idle), .snoop_i(snoop),
    .clk_present_i(clk_present), .state_o(state), .grant_cyc_o(grant_cyc),
    .halt_cyc_o(halt_cyc), .recog_o(recog)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    stop_req = 0; halt_exec = 0; intr = 0; nmi = 0; smi = 0;
    hard_rst = 0; soft_rst = 0; idle = 0; snoop = 0; clk_present = 1;
  endtask

  task automatic core_reset();
    quiet();
    hard_rst = 1;
    tick();
    hard_rst = 0;
  endtask

  task automatic to_grant();
    core_reset();
    stop_req = 1; idle = 1;
    tick();
  endtask

  task automatic to_stopped();
    to_grant();
    clk_present = 0;
    tick();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    quiet();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 state", state, 0);
    check("R1 strobes", {grant_cyc, halt_cyc}, 0);
    check("R1 recog", recog, 3);

    // R2 halt entry, R3 each break event
    for (int b = 0; b < 5; b++) begin
      core_reset();
      halt_exec = 1; tick();
      check("R2 halted", state, 1);
      check("R2 strobe on", halt_cyc, 1);
      halt_exec = 0; tick();
      check("R2 strobe off", halt_cyc, 0);
      intr = (b == 0); nmi = (b == 1); smi = (b == 2);
      soft_rst = (b == 3); hard_rst = (b == 4);
      tick();
      check("R3 break to run", state, 0);
      quiet();
    end

    // R4 idle gating from running and from halted
    for (int f = 0; f < 2; f++) begin
      core_reset();
      if (f == 1) begin halt_exec = 1; tick(); halt_exec = 0; end
      stop_req = 1;
      repeat (3) tick();
      check("R4 held off", state, f);
      idle = 1; tick();
      check("R4 granted", state, 2);
      check("R4 strobe on", grant_cyc, 1);
      tick();
      check("R4 strobe off", grant_cyc, 0);
    end

    // R5 masked inputs in stop-granted
    to_grant();
    halt_exec = 1; intr = 1; nmi = 1; smi = 1; soft_rst = 1;
    tick();
    check("R5 state kept", state, 2);
    check("R5 recog", recog, 1);

    // R6 clock stopped
    to_stopped();
    check("R6 stopped", state, 3);
    check("R6 recog", recog, 0);
    clk_present = 0; snoop = 1; intr = 1; stop_req = 0;
    tick();
    check("R6 ignores inputs", state, 3);

    // R7 dropout position sweep
    for (int k = 0; k < LAT; k++) begin
      to_stopped();
      clk_present = 1;
      repeat (k) tick();
      clk_present = 0; tick();
      clk_present = 1;
      repeat (LAT - 1) tick();
      check("R7 still waiting", state, 3);
      tick();
      check("R7 back to grant", state, 2);
      check("R7 no strobe", grant_cyc, 0);
    end

    // R8 snoop
    to_grant();
    snoop = 1; tick();
    check("R8 snooping", state, 4);
    stop_req = 0; tick();
    check("R8 stop ignored", state, 4);
    stop_req = 1; snoop = 0; tick();
    check("R8 back", state, 2);
    check("R8 no strobe", grant_cyc, 0);

    // R9 wake-up masking
    to_grant();
    stop_req = 0; tick();
    check("R9 running", state, 0);
    check("R9 recog narrow", recog, 1);
    halt_exec = 1; tick();
    check("R9 halt ignored", state, 0);
    check("R9 recog full", recog, 3);
    tick();
    check("R9 halt taken", state, 1);
    halt_exec = 0;

    // R10 deassertion gap sweep
    for (int g = 1; g <= MIN + 1; g++) begin
      to_grant();
      stop_req = 0;
      repeat (g) tick();
      stop_req = 1; idle = 1; tick();
      check("R10 rearm", state, (g >= MIN) ? 2 : 0);
    end

    // R11 core reset from every state
    for (int s = 1; s <= 4; s++) begin
      if (s == 1) begin core_reset(); halt_exec = 1; tick(); halt_exec = 0; end
      else if (s == 2) to_grant();
      else if (s == 3) begin to_stopped(); clk_present = 1; repeat (LAT - 1) tick(); end
      else begin to_grant(); snoop = 1; tick(); end
      check("R11 reached", state, s);
      hard_rst = 1; tick(); hard_rst = 0;
      check("R11 forced run", state, 0);
    end
    // R11 latency count cleared: a fresh full window is needed
    to_stopped();
    clk_present = 1;
    repeat (LAT - 1) tick();
    check("R11 full window", state, 3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule